// File: doc/BRIEF.md
# Configuration Store with Security Lock

This block controls the configuration memory of a programmable logic array. A small command bus drives it. The bus can bulk-erase the store, program one configuration word, read one word back for verification, and set a security lock. It can also program or read a 24-bit signature word. The lock blocks both verify reads and programming of the array. Only a full bulk erase removes the lock, and that erase also returns every word to its open (all ones) state. The signature word stays readable at all times, including while the lock is set. Teams use the signature to record a pattern identifier or a design revision.

A command is taken when the valid strobe is high and the block is not busy. Every command except erase completes in one cycle, and its completion pulse arrives in the next cycle. An erase keeps the busy output high for a parameterised number of cycles. A refused command still completes, but it raises the error output for that one cycle and returns zero data.

Top module: `cfg_store`

## Requirements
- R1: After reset, busy_o, done_o and err_o are low and rdata_o is zero. Every array word reads all ones (open), the lock is clear and the signature reads zero.
- R2: Op codes are 0 erase, 1 program, 2 verify read, 3 set lock, 4 program signature, 5 read signature, 6 program then lock. A command is accepted at a rising edge where cmd_valid_i is high and busy_o is low. A one-cycle command raises done_o for exactly the following cycle. A command presented while busy_o is high has no effect and produces no done_o.
- R3: After an erase is accepted, busy_o is high for exactly ERASE_CYC cycles. In the next cycle busy_o is low and done_o is high with err_o low.
- R4: A completed erase sets every array word to all ones, clears the lock and clears the signature to zero.
- R5: With the lock clear, op 1 stores cmd_wdata_i[DATA_W-1:0] at cmd_addr_i. Op 2 returns the stored word zero-extended on rdata_o with done_o, and err_o stays low.
- R6: Op 3 sets the lock. Op 6 stores the word and sets the lock in the same cycle, without error.
- R7: With the lock set, op 2 is refused. It gives done_o with err_o high for one cycle and rdata_o zero.
- R8: With the lock set, ops 1, 4 and 6 are refused with err_o high. The signature keeps its previous value.
- R9: Op 5 returns the signature in rdata_o[23:0] with err_o low, whether the lock is set or not.
- R10: Op 7 is illegal. It gives done_o with err_o high and changes no stored state.
- R11: A command accepted in the cycle where an erase's done_o is high acts on the erased state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Operation code |
| cmd_addr_i | input | ADDR_W | Array word address |
| cmd_wdata_i | input | SIG_W | Write data (array uses low DATA_W bits) |
| busy_o | output | 1 | Erase in progress |
| done_o | output | 1 | Command completed (one cycle) |
| err_o | output | 1 | Command refused (one cycle) |
| rdata_o | output | SIG_W | Read data, valid with done_o |

## Verification
Two functions can coincide. An erase can retire in the same cycle that a new command is accepted. A single op can also program a word and set the lock in one edge. The bench drives a program command in the very cycle the erase pulses done_o. It then reads that word back, expecting the new value beside all-ones neighbours, a clear lock and a zero signature. For the combined op, a verify read must be refused right after it completes with no error, and a later erase must restore the word to all ones.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;
  typedef enum logic [2:0] {
    OP_ERASE     = 3'd0,
    OP_PROG      = 3'd1,
    OP_READ      = 3'd2,
    OP_LOCK      = 3'd3,
    OP_SIG_PROG  = 3'd4,
    OP_SIG_READ  = 3'd5,
    OP_PROG_LOCK = 3'd6
  } op_e;
endpackage

// File: rtl/cfg_seq.sv
module cfg_seq #(
  parameter int ERASE_CYC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [2:0] op_i,
  output logic       busy_o,
  output logic       fire_o,
  output logic       erase_done_o
);
  import cfg_store_pkg::*;
  localparam int CNT_W = $clog2(ERASE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign busy_o       = (cnt_q != '0);
  assign accept       = valid_i && !busy_o;
  assign fire_o       = accept && (op_i != OP_ERASE);
  assign erase_done_o = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (accept && op_i == OP_ERASE) cnt_q <= CNT_W'(ERASE_CYC);
    else if (busy_o)                     cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/cfg_array.sv
module cfg_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  word_q <= '1;
      else if (erase_i)                             word_q <= '1;
      else if (wr_en_i && addr_i == ADDR_W'(i))     word_q <= wr_data_i;
    end
    assign words[i] = word_q;
  end

  assign rd_data_o = words[addr_i];
endmodule

// File: rtl/cfg_guard.sv
module cfg_guard #(
  parameter int SIG_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             erase_i,
  input  logic             lock_set_i,
  input  logic             sig_wr_i,
  input  logic [SIG_W-1:0] sig_data_i,
  output logic             locked_o,
  output logic [SIG_W-1:0] sig_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_o <= 1'b0;
      sig_o    <= '0;
    end else if (erase_i) begin
      locked_o <= 1'b0;
      sig_o    <= '0;
    end else begin
      if (lock_set_i) locked_o <= 1'b1;
      if (sig_wr_i)   sig_o    <= sig_data_i;
    end
  end
endmodule

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int SIG_W     = 24,
  parameter int ERASE_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [SIG_W-1:0]  cmd_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [SIG_W-1:0]  rdata_o
);
  import cfg_store_pkg::*;

  logic              fire, erase_done, locked_w;
  logic              illegal, refuse, wr_en, lock_set, sig_wr;
  logic [DATA_W-1:0] arr_rd;
  logic [SIG_W-1:0]  sig_w, rd_val;

  cfg_seq #(.ERASE_CYC(ERASE_CYC)) u_seq (
    .clk_i, .rst_ni, .valid_i(cmd_valid_i), .op_i(cmd_op_i),
    .busy_o, .fire_o(fire), .erase_done_o(erase_done)
  );

  always_comb begin
    illegal = 1'b0;
    refuse  = 1'b0;
    rd_val  = '0;
    if (fire) begin
      case (cmd_op_i)
        OP_PROG, OP_PROG_LOCK, OP_READ, OP_SIG_PROG: refuse = locked_w;
        OP_LOCK, OP_SIG_READ: refuse = 1'b0;
        default: illegal = 1'b1;
      endcase
      refuse = refuse | illegal;
      if (!refuse && cmd_op_i == OP_READ)     rd_val = SIG_W'(arr_rd);
      if (cmd_op_i == OP_SIG_READ)            rd_val = sig_w;
    end
  end

  assign wr_en    = fire && !refuse && (cmd_op_i == OP_PROG || cmd_op_i == OP_PROG_LOCK);
  assign lock_set = fire && !refuse && (cmd_op_i == OP_LOCK || cmd_op_i == OP_PROG_LOCK);
  assign sig_wr   = fire && !refuse && (cmd_op_i == OP_SIG_PROG);

  cfg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i, .rst_ni, .erase_i(erase_done), .wr_en_i(wr_en),
    .addr_i(cmd_addr_i), .wr_data_i(cmd_wdata_i[DATA_W-1:0]), .rd_data_o(arr_rd)
  );

  cfg_guard #(.SIG_W(SIG_W)) u_guard (
    .clk_i, .rst_ni, .erase_i(erase_done), .lock_set_i(lock_set),
    .sig_wr_i(sig_wr), .sig_data_i(cmd_wdata_i), .locked_o(locked_w), .sig_o(sig_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o  <= fire | erase_done;
      err_o   <= refuse;
      rdata_o <= rd_val;
    end
  end
endmodule

// File: rtl/cfg_store_chk.sv
module cfg_store_chk #(
  parameter int ADDR_W = 4,
  parameter int SIG_W  = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [2:0]       cmd_op_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic [SIG_W-1:0] rdata_o,
  input logic             locked_w
);
  import cfg_store_pkg::*;

  a_r2_no_done_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);

  a_r3_erase_retire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o && !err_o);

  a_r4_lock_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !locked_w);

  a_r7_read_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && cmd_op_i == OP_READ && locked_w)
      |=> err_o && done_o && rdata_o == '0);

  a_r9_sig_read_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && cmd_op_i == OP_SIG_READ) |=> done_o && !err_o);

  a_r10_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o && rdata_o == '0);
endmodule

bind cfg_store cfg_store_chk #(.ADDR_W(ADDR_W), .SIG_W(SIG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o),
  .locked_w(locked_w)
);

// File: tb/cfg_store_tb.sv
module cfg_store_tb;
  import cfg_store_pkg::*;
  localparam int CLK_P     = 10;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 16;
  localparam int SIG_W     = 24;
  localparam int ERASE_CYC = 8;
  localparam logic [SIG_W-1:0] OPEN = SIG_W'({DATA_W{1'b1}});

  logic              clk = 1'b0, rst_ni = 1'b0;
  logic              cmd_valid_i = 1'b0;
  logic [2:0]        cmd_op_i = '0;
  logic [ADDR_W-1:0] cmd_addr_i = '0;
  logic [SIG_W-1:0]  cmd_wdata_i = '0;
  logic              busy_o, done_o, err_o;
  logic [SIG_W-1:0]  rdata_o;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  cfg_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_W(SIG_W), .ERASE_CYC(ERASE_CYC)) u_dut (
    .clk_i(clk), .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_addr_i, .cmd_wdata_i,
    .busy_o, .done_o, .err_o, .rdata_o
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // enters and leaves at a negedge; samples the cycle after acceptance
  task automatic cmd(input logic [2:0] op, input logic [ADDR_W-1:0] a, input logic [SIG_W-1:0] d);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_addr_i = a; cmd_wdata_i = d;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input logic err, input logic [SIG_W-1:0] d);
    chk({tag, " done"}, 32'(done_o), 32'd1);
    chk({tag, " err"},  32'(err_o),  32'(err));
    chk({tag, " data"}, 32'(rdata_o), 32'(d));
  endtask

  task automatic erase_run(input string tag);
    int n = 0;
    cmd(OP_ERASE, '0, '0);
    while (busy_o && n < 100) begin
      n++;
      if (n == 2) begin
        cmd_valid_i = 1'b1; cmd_op_i = OP_PROG; cmd_addr_i = 4'd3; cmd_wdata_i = 24'h0;
      end else cmd_valid_i = 1'b0;
      chk({tag, " R2 no done while busy"}, 32'(done_o), 32'd0);
      @(negedge clk);
    end
    cmd_valid_i = 1'b0;
    chk({tag, " R3 busy length"}, 32'(n), 32'(ERASE_CYC));
    chk({tag, " R3 done after erase"}, 32'(done_o), 32'd1);
    chk({tag, " R3 no err"}, 32'(err_o), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 busy", 32'(busy_o), 0); chk("R1 done", 32'(done_o), 0);
    chk("R1 err", 32'(err_o), 0);   chk("R1 rdata", 32'(rdata_o), 0);
    cmd(OP_READ, 4'd0, '0);     expect_rsp("R1 open word", 1'b0, OPEN);
    cmd(OP_SIG_READ, '0, '0);   expect_rsp("R1 sig zero", 1'b0, '0);
  endtask

  task automatic t_prog_read;
    cmd(OP_PROG, 4'd3, 24'hFFA5C3);  expect_rsp("R5 prog", 1'b0, '0);
    cmd(OP_PROG, 4'd15, 24'h001234); expect_rsp("R5 prog15", 1'b0, '0);
    cmd(OP_READ, 4'd3, '0);  expect_rsp("R5 read3", 1'b0, 24'h00A5C3);
    cmd(OP_READ, 4'd15, '0); expect_rsp("R5 read15", 1'b0, 24'h001234);
    cmd(OP_READ, 4'd4, '0);  expect_rsp("R5 untouched", 1'b0, OPEN);
    @(negedge clk);
    chk("R2 done one cycle", 32'(done_o), 0);
  endtask

  task automatic t_sig;
    cmd(OP_SIG_PROG, '0, 24'hABCDEF); expect_rsp("R9 sig prog", 1'b0, '0);
    cmd(OP_SIG_READ, '0, '0);         expect_rsp("R9 sig read", 1'b0, 24'hABCDEF);
  endtask

  task automatic t_illegal;
    cmd(3'd7, 4'd3, 24'h0);   expect_rsp("R10 illegal", 1'b1, '0);
    cmd(OP_READ, 4'd3, '0);   expect_rsp("R10 no change", 1'b0, 24'h00A5C3);
  endtask

  task automatic t_erase_basic;
    erase_run("R4 erase1");
    cmd(OP_READ, 4'd3, '0);   expect_rsp("R4 word3 open (R2 ignored prog)", 1'b0, OPEN);
    cmd(OP_READ, 4'd15, '0);  expect_rsp("R4 word15 open", 1'b0, OPEN);
    cmd(OP_SIG_READ, '0, '0); expect_rsp("R4 sig cleared", 1'b0, '0);
  endtask

  task automatic t_lock;
    cmd(OP_PROG, 4'd2, 24'h000F0F);  expect_rsp("R6 pre prog", 1'b0, '0);
    cmd(OP_SIG_PROG, '0, 24'h123456); expect_rsp("R6 pre sig", 1'b0, '0);
    cmd(OP_LOCK, '0, '0);             expect_rsp("R6 lock", 1'b0, '0);
    cmd(OP_READ, 4'd2, '0);           expect_rsp("R7 read refused", 1'b1, '0);
    @(negedge clk);
    chk("R7 err one cycle", 32'(err_o), 0);
    cmd(OP_SIG_READ, '0, '0);         expect_rsp("R9 sig while locked", 1'b0, 24'h123456);
    cmd(OP_PROG, 4'd2, 24'h0);        expect_rsp("R8 prog refused", 1'b1, '0);
    cmd(OP_PROG_LOCK, 4'd2, 24'h0);   expect_rsp("R8 prog_lock refused", 1'b1, '0);
    cmd(OP_SIG_PROG, '0, 24'h999999); expect_rsp("R8 sig prog refused", 1'b1, '0);
    cmd(OP_SIG_READ, '0, '0);         expect_rsp("R8 sig unchanged", 1'b0, 24'h123456);
  endtask

  task automatic t_overlap;
    erase_run("R11 erase2");
    cmd(OP_PROG, 4'd5, 24'h005555);   expect_rsp("R11 prog in done cycle", 1'b0, '0);
    cmd(OP_READ, 4'd5, '0);           expect_rsp("R11 new word", 1'b0, 24'h005555);
    cmd(OP_READ, 4'd2, '0);           expect_rsp("R11 R4 neighbour open, lock clear", 1'b0, OPEN);
    cmd(OP_SIG_READ, '0, '0);         expect_rsp("R11 R4 sig cleared", 1'b0, '0);
  endtask

  task automatic t_prog_lock;
    cmd(OP_PROG_LOCK, 4'd6, 24'h006666); expect_rsp("R6 prog_lock", 1'b0, '0);
    cmd(OP_READ, 4'd6, '0);              expect_rsp("R6 locked after prog_lock", 1'b1, '0);
    erase_run("R6 erase3");
    cmd(OP_READ, 4'd6, '0);              expect_rsp("R6 R4 open after erase", 1'b0, OPEN);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_prog_read();
    t_sig();
    t_illegal();
    t_erase_basic();
    t_lock();
    t_overlap();
    t_prog_lock();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule